// File: doc/BRIEF.md
# Framebuffer Control and Timing Register Block

This block is the register front end of a framebuffer display controller. It decodes byte, halfword and word accesses in a 64 KB register window. It holds the display control byte, the pixel-path byte, a read-only monitor-status byte and a read-only version byte. It also holds four 16-bit blanking registers, from which it works out the visible resolution that the rest of the display pipeline scans.

A small indirect window passes byte accesses through to the video DAC's address, lookup-data, control and mode registers. Alongside it the block keeps the colour-sequence counter that tracks which colour component of a lookup entry comes next. The control fields, the resolution, a one-cycle size-changed pulse and the DAC state are brought out as ports for the scan-out and DAC sequencing logic.

Access data is right-justified: byte data uses bits 7:0, halfword data uses bits 15:0. Read data is registered. The size code on `acc_size` is 0 for byte, 1 for halfword, 2 for word; code 3 behaves like a word access.

Top module: `fbreg_ctrl`

## Requirements
- R1: After reset the control byte reads 0x40: video enable is 1, interrupt enable is 0 and the pixel mode is 00. The pixel-path byte, the blanking registers, the derived width and height, the DAC registers and `size_changed` are all zero.
- R2: A byte write to offset 0x0000 stores the whole control byte, and a byte read of 0x0000 returns it. Bit 7 drives `irq_en`, bit 6 drives `video_en`, and bits 5:4 drive `pix_mode` (00 = 8 bpp, 10 = 16 bpp, 11 = 32 bpp).
- R3: A byte write to offset 0x0001 keeps only data bits 7:4. A byte read of 0x0001 returns those bits with bits 3:0 zero, and `pix_path` shows the stored nibble.
- R4: A byte read of offset 0x0004 returns the monitor code in bits 3:1, with all other bits zero. The code is chosen from the CFG_WIDTH parameter: width ≥1600 gives 1, ≥1280 gives 2, ≥1152 gives 7, and anything else gives 0.
- R5: A byte read of offset 0x0006 returns 0x30.
- R6: Halfword accesses reach the blanking registers: horizontal start at 0x18, horizontal clear at 0x1A, vertical start at 0x22 and vertical clear at 0x24. Halfword writes to 0x1C, 0x1E, 0x20, 0x26 and 0x28 are accepted, change no register, and those offsets read as zero.
- R7: `size_changed` is high for exactly the cycle after each halfword write to 0x1A or 0x24. No other access raises it.
- R8: In the cycle after `size_changed` is high, if horizontal start > horizontal clear and vertical start > vertical clear, then `disp_width` becomes 4×(hstart−hclear) and `disp_height` becomes vstart−vclear. Otherwise, and at all other times, both outputs hold their values.
- R9: Byte accesses with (address AND 0xFC00) = 0x2000 reach the DAC window, and address bits 9:8 select the register: 0 address, 1 lookup data, 2 control, 3 mode. The address and mode registers read back the last value written (also shown on `dac_addr` and `dac_mode`). Lookup data and control read as zero.
- R10: A write to the DAC address register clears `dac_seq`. Each byte read or write of the DAC lookup-data register adds one to it, wrapping modulo 2^SEQ_W. No other access changes it.
- R11: Reads of unmapped locations return zero, and writes to them change nothing. Unmapped locations include every word access, halfword accesses to the byte registers and the DAC window, and byte accesses to the blanking offsets.
- R12: `acc_rdata` takes the read result at the clock edge that accepts a read. It holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_en | input | 1 | Access request, one access per cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_size | input | 2 | 0 byte, 1 halfword, 2 word |
| acc_addr | input | ADDR_W (16) | Byte offset in the register window |
| acc_wdata | input | DATA_W (32) | Right-justified write data |
| acc_rdata | output | DATA_W (32) | Registered right-justified read data |
| irq_en | output | 1 | Control bit 7 |
| video_en | output | 1 | Control bit 6 |
| pix_mode | output | 2 | Control bits 5:4 |
| pix_path | output | 4 | Stored upper nibble of the pixel-path byte |
| disp_width | output | TIM_W+2 (18) | Derived active width in pixels |
| disp_height | output | TIM_W (16) | Derived active height in lines |
| size_changed | output | 1 | One-cycle pulse after a clear-register write |
| dac_addr | output | 8 | DAC address register |
| dac_mode | output | 8 | DAC mode register |
| dac_seq | output | SEQ_W (8) | Colour-sequence counter |

## Verification
The assertions assume that `acc_en`, `acc_wr`, `acc_size` and `acc_addr` are known whenever reset is released. They also assume one access per cycle, with no wait state. The bench drives every input from a known value at time zero and changes inputs only on the falling edge. Its random accesses are drawn from a fixed pool of mapped, sync, DAC and out-of-window offsets with all three sizes, so every decoded target is reached while the access protocol stays inside those assumptions.

// File: rtl/fbreg_pkg.sv
package fbreg_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_RSVD = 2'd3
   } acc_size_e;

   typedef enum logic [3:0] {
      TG_NONE,
      TG_CTRL,
      TG_PATH,
      TG_STAT,
      TG_VER,
      TG_HBS,
      TG_HBC,
      TG_VBS,
      TG_VBC,
      TG_SYNC,
      TG_DAC
   } tgt_e;

   typedef enum logic [1:0] {
      DX_ADDR = 2'd0,
      DX_LUT  = 2'd1,
      DX_CTL  = 2'd2,
      DX_MODE = 2'd3
   } dac_idx_e;

   typedef struct packed {
      logic       irq_en;
      logic       vid_en;
      logic [1:0] pix_mode;
      logic [3:0] spare;
   } ctrl_t;

   localparam logic [15:0] OFF_CTRL = 16'h0000;
   localparam logic [15:0] OFF_PATH = 16'h0001;
   localparam logic [15:0] OFF_STAT = 16'h0004;
   localparam logic [15:0] OFF_VER  = 16'h0006;
   localparam logic [15:0] OFF_HBS  = 16'h0018;
   localparam logic [15:0] OFF_HBC  = 16'h001A;
   localparam logic [15:0] OFF_VBS  = 16'h0022;
   localparam logic [15:0] OFF_VBC  = 16'h0024;
   localparam logic [15:0] DAC_MASK = 16'hFC00;
   localparam logic [15:0] DAC_BASE = 16'h2000;

   localparam logic [7:0]  HW_VERSION = 8'h30;
   localparam ctrl_t       CTRL_RESET = '{irq_en: 1'b0, vid_en: 1'b1,
                                          pix_mode: 2'b00, spare: 4'h0};

   function automatic logic [2:0] mon_code(input int unsigned w);
      if (w >= 1600)      return 3'd1;
      else if (w >= 1280) return 3'd2;
      else if (w >= 1152) return 3'd7;
      else                return 3'd0;
   endfunction

endpackage

// File: rtl/fbreg_decode.sv
module fbreg_decode
   import fbreg_pkg::*;
(
   input  logic [1:0]  size_i,
   input  logic [15:0] addr_i,
   output tgt_e        tgt_o,
   output dac_idx_e    dac_idx_o
);

   always_comb begin
      tgt_o     = TG_NONE;
      dac_idx_o = dac_idx_e'(addr_i[9:8]);
      case (acc_size_e'(size_i))
         SZ_BYTE: begin
            if ((addr_i & DAC_MASK) == DAC_BASE) begin
               tgt_o = TG_DAC;
            end else begin
               case (addr_i)
                  OFF_CTRL: tgt_o = TG_CTRL;
                  OFF_PATH: tgt_o = TG_PATH;
                  OFF_STAT: tgt_o = TG_STAT;
                  OFF_VER:  tgt_o = TG_VER;
                  default:  tgt_o = TG_NONE;
               endcase
            end
         end
         SZ_HALF: begin
            case (addr_i)
               OFF_HBS: tgt_o = TG_HBS;
               OFF_HBC: tgt_o = TG_HBC;
               OFF_VBS: tgt_o = TG_VBS;
               OFF_VBC: tgt_o = TG_VBC;
               16'h001C, 16'h001E, 16'h0020,
               16'h0026, 16'h0028: tgt_o = TG_SYNC;
               default: tgt_o = TG_NONE;
            endcase
         end
         default: tgt_o = TG_NONE;
      endcase
   end

endmodule

// File: rtl/fbreg_dac.sv
module fbreg_dac
   import fbreg_pkg::*;
#(
   parameter int SEQ_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_i,
   input  logic             rd_i,
   input  dac_idx_e         idx_i,
   input  logic [7:0]       wdata_i,
   output logic [7:0]       addr_o,
   output logic [7:0]       mode_o,
   output logic [SEQ_W-1:0] seq_o,
   output logic [7:0]       rdata_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_o <= '0;
         mode_o <= '0;
         seq_o  <= '0;
      end else if (wr_i) begin
         case (idx_i)
            DX_ADDR: begin
               addr_o <= wdata_i;
               seq_o  <= '0;
            end
            DX_LUT:  seq_o  <= seq_o + SEQ_W'(1);
            DX_MODE: mode_o <= wdata_i;
            default: ;
         endcase
      end else if (rd_i && idx_i == DX_LUT) begin
         seq_o <= seq_o + SEQ_W'(1);
      end
   end

   always_comb begin
      case (idx_i)
         DX_ADDR: rdata_o = addr_o;
         DX_MODE: rdata_o = mode_o;
         default: rdata_o = '0;
      endcase
   end

endmodule

// File: rtl/fbreg_geom.sv
module fbreg_geom #(
   parameter  int TIM_W = 16,
   localparam int WID_W = TIM_W + 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [3:0]       we_i,
   input  logic [TIM_W-1:0] wdata_i,
   output logic [TIM_W-1:0] hbs_o,
   output logic [TIM_W-1:0] hbc_o,
   output logic [TIM_W-1:0] vbs_o,
   output logic [TIM_W-1:0] vbc_o,
   output logic             size_chg_o,
   output logic [WID_W-1:0] width_o,
   output logic [TIM_W-1:0] height_o
);

   localparam int IX_HBS = 0;
   localparam int IX_HBC = 1;
   localparam int IX_VBS = 2;
   localparam int IX_VBC = 3;

   logic [TIM_W-1:0] tim_q [4];
   logic             h_pos;
   logic             v_pos;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < 4; i++) tim_q[i] <= '0;
      end else begin
         for (int i = 0; i < 4; i++) begin
            if (we_i[i]) tim_q[i] <= wdata_i;
         end
      end
   end

   assign hbs_o = tim_q[IX_HBS];
   assign hbc_o = tim_q[IX_HBC];
   assign vbs_o = tim_q[IX_VBS];
   assign vbc_o = tim_q[IX_VBC];

   assign h_pos = tim_q[IX_HBS] > tim_q[IX_HBC];
   assign v_pos = tim_q[IX_VBS] > tim_q[IX_VBC];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         size_chg_o <= 1'b0;
         width_o    <= '0;
         height_o   <= '0;
      end else begin
         size_chg_o <= we_i[IX_HBC] | we_i[IX_VBC];
         if (size_chg_o && h_pos && v_pos) begin
            width_o  <= {tim_q[IX_HBS] - tim_q[IX_HBC], 2'b00};
            height_o <= tim_q[IX_VBS] - tim_q[IX_VBC];
         end
      end
   end

endmodule

// File: rtl/fbreg_ctrl.sv
module fbreg_ctrl
   import fbreg_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 32,
   parameter int TIM_W     = 16,
   parameter int SEQ_W     = 8,
   parameter int CFG_WIDTH = 1152,
   parameter bit RD_REG    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_en,
   input  logic              acc_wr,
   input  logic [1:0]        acc_size,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [DATA_W-1:0] acc_wdata,
   output logic [DATA_W-1:0] acc_rdata,
   output logic              irq_en,
   output logic              video_en,
   output logic [1:0]        pix_mode,
   output logic [3:0]        pix_path,
   output logic [TIM_W+1:0]  disp_width,
   output logic [TIM_W-1:0]  disp_height,
   output logic              size_changed,
   output logic [7:0]        dac_addr,
   output logic [7:0]        dac_mode,
   output logic [SEQ_W-1:0]  dac_seq
);

   localparam logic [2:0] MON = mon_code(CFG_WIDTH);
   localparam logic [7:0] STAT_VAL = {4'h0, MON, 1'b0};

   if (ADDR_W < 16 || DATA_W < 8 || DATA_W < TIM_W || TIM_W < 2 || SEQ_W < 1)
   begin : g_param_bad
      initial $fatal(1, "fbreg_ctrl: parameter set out of range");
   end

   tgt_e             tgt;
   dac_idx_e         dac_idx;
   logic             wr_go;
   logic             rd_go;
   ctrl_t            ctrl_q;
   logic [3:0]       path_q;
   logic [3:0]       tim_we;
   logic [TIM_W-1:0] hbs, hbc, vbs, vbc;
   logic [7:0]       dac_rd;
   logic [DATA_W-1:0] rd_val;

   assign wr_go = acc_en & acc_wr;
   assign rd_go = acc_en & ~acc_wr;

   fbreg_decode u_decode (
      .size_i    (acc_size),
      .addr_i    (acc_addr[15:0]),
      .tgt_o     (tgt),
      .dac_idx_o (dac_idx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= CTRL_RESET;
         path_q <= '0;
      end else if (wr_go) begin
         if (tgt == TG_CTRL) ctrl_q <= ctrl_t'(acc_wdata[7:0]);
         if (tgt == TG_PATH) path_q <= acc_wdata[7:4];
      end
   end

   assign irq_en   = ctrl_q.irq_en;
   assign video_en = ctrl_q.vid_en;
   assign pix_mode = ctrl_q.pix_mode;
   assign pix_path = path_q;

   assign tim_we = {wr_go && tgt == TG_VBC, wr_go && tgt == TG_VBS,
                    wr_go && tgt == TG_HBC, wr_go && tgt == TG_HBS};

   fbreg_geom #(.TIM_W(TIM_W)) u_geom (
      .clk        (clk),
      .rst_n      (rst_n),
      .we_i       (tim_we),
      .wdata_i    (acc_wdata[TIM_W-1:0]),
      .hbs_o      (hbs),
      .hbc_o      (hbc),
      .vbs_o      (vbs),
      .vbc_o      (vbc),
      .size_chg_o (size_changed),
      .width_o    (disp_width),
      .height_o   (disp_height)
   );

   fbreg_dac #(.SEQ_W(SEQ_W)) u_dac (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (wr_go && tgt == TG_DAC),
      .rd_i    (rd_go && tgt == TG_DAC),
      .idx_i   (dac_idx),
      .wdata_i (acc_wdata[7:0]),
      .addr_o  (dac_addr),
      .mode_o  (dac_mode),
      .seq_o   (dac_seq),
      .rdata_o (dac_rd)
   );

   always_comb begin
      rd_val = '0;
      case (tgt)
         TG_CTRL: rd_val[7:0]       = ctrl_q;
         TG_PATH: rd_val[7:0]       = {path_q, 4'h0};
         TG_STAT: rd_val[7:0]       = STAT_VAL;
         TG_VER:  rd_val[7:0]       = HW_VERSION;
         TG_HBS:  rd_val[TIM_W-1:0] = hbs;
         TG_HBC:  rd_val[TIM_W-1:0] = hbc;
         TG_VBS:  rd_val[TIM_W-1:0] = vbs;
         TG_VBC:  rd_val[TIM_W-1:0] = vbc;
         TG_DAC:  rd_val[7:0]       = dac_rd;
         default: rd_val            = '0;
      endcase
   end

   if (RD_REG) begin : g_rd_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     acc_rdata <= '0;
         else if (rd_go) acc_rdata <= rd_val;
      end
   end else begin : g_rd_comb
      assign acc_rdata = rd_go ? rd_val : '0;
   end

   if (DATA_W > TIM_W) begin : g_unused_data
      logic unused_wdata;
      assign unused_wdata = ^acc_wdata[DATA_W-1:TIM_W];
   end
   if (ADDR_W > 16) begin : g_unused_addr
      logic unused_addr;
      assign unused_addr = ^acc_addr[ADDR_W-1:16];
   end

endmodule

// File: rtl/fbreg_ctrl_chk.sv
module fbreg_ctrl_chk #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 32,
   parameter int TIM_W  = 16,
   parameter int SEQ_W  = 8,
   parameter bit RD_REG = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              acc_en,
   input logic              acc_wr,
   input logic [1:0]        acc_size,
   input logic [ADDR_W-1:0] acc_addr,
   input logic [DATA_W-1:0] acc_wdata,
   input logic [DATA_W-1:0] acc_rdata,
   input logic              irq_en,
   input logic              video_en,
   input logic [1:0]        pix_mode,
   input logic [3:0]        pix_path,
   input logic [TIM_W+1:0]  disp_width,
   input logic [TIM_W-1:0]  disp_height,
   input logic              size_changed,
   input logic [7:0]        dac_addr,
   input logic [7:0]        dac_mode,
   input logic [SEQ_W-1:0]  dac_seq
);

   logic        byte_rd;
   logic        byte_wr;
   logic        clr_wr;
   logic        dac_hit;
   logic [15:0] a16;
   logic        unused_chk;

   assign a16     = acc_addr[15:0];
   assign byte_rd = acc_en && !acc_wr && acc_size == 2'd0;
   assign byte_wr = acc_en && acc_wr && acc_size == 2'd0;
   assign clr_wr  = acc_en && acc_wr && acc_size == 2'd1 &&
                    (a16 == 16'h001A || a16 == 16'h0024);
   assign dac_hit = (a16 & 16'hFC00) == 16'h2000;
   assign unused_chk = ^{acc_wdata, acc_rdata, pix_path, dac_addr, dac_mode};

   AST_CTRL_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_wr && a16 == 16'h0000) |=>
      ({irq_en, video_en, pix_mode} == $past(acc_wdata[7:4])));            // R2

   AST_PULSE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      size_changed |-> $past(clr_wr));                                     // R7

   AST_PULSE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      clr_wr |=> size_changed);                                            // R7

   AST_GEOM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(size_changed) |-> ($stable(disp_width) && $stable(disp_height))); // R8

   AST_SEQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_wr && dac_hit && a16[9:8] == 2'd0) |=> (dac_seq == '0));       // R10

   if (RD_REG) begin : g_rd_props
      AST_PATH_LOW: assert property (@(posedge clk) disable iff (!rst_n)
         (byte_rd && a16 == 16'h0001) |=> (acc_rdata[3:0] == 4'h0));       // R3

      AST_VERSION: assert property (@(posedge clk) disable iff (!rst_n)
         (byte_rd && a16 == 16'h0006) |=> (acc_rdata == DATA_W'(8'h30)));   // R5

      AST_WORD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
         (acc_en && !acc_wr && acc_size[1]) |=> (acc_rdata == '0));        // R11

      AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
         !(acc_en && !acc_wr) |=> $stable(acc_rdata));                     // R12
   end

endmodule

bind fbreg_ctrl fbreg_ctrl_chk #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W),
   .TIM_W  (TIM_W),
   .SEQ_W  (SEQ_W),
   .RD_REG (RD_REG)
) u_chk (.*);

// File: tb/fbreg_ctrl_bench.sv
module fbreg_ctrl_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_en = 1'b0;
   logic        acc_wr = 1'b0;
   logic [1:0]  acc_size = 2'd0;
   logic [15:0] acc_addr = 16'h0;
   logic [31:0] acc_wdata = 32'h0;
   logic [31:0] acc_rdata;
   logic        irq_en, video_en, size_changed;
   logic [1:0]  pix_mode;
   logic [3:0]  pix_path;
   logic [17:0] disp_width;
   logic [15:0] disp_height;
   logic [7:0]  dac_addr, dac_mode, dac_seq;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   // bench model
   logic [7:0]  m_ctrl;
   logic [3:0]  m_path;
   logic [15:0] m_hbs, m_hbc, m_vbs, m_vbc, m_h;
   logic [17:0] m_w;
   logic [7:0]  m_daddr, m_dmode, m_seq;
   logic        m_pend;
   logic [31:0] m_rd;

   always #5 clk = ~clk;

   fbreg_ctrl u_fbreg_ctrl (
      .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
      .acc_size(acc_size), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
      .acc_rdata(acc_rdata), .irq_en(irq_en), .video_en(video_en),
      .pix_mode(pix_mode), .pix_path(pix_path), .disp_width(disp_width),
      .disp_height(disp_height), .size_changed(size_changed),
      .dac_addr(dac_addr), .dac_mode(dac_mode), .dac_seq(dac_seq)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [2:0] exp_mon(input int w);
      if (w >= 1600) return 3'd1;
      if (w >= 1280) return 3'd2;
      if (w >= 1152) return 3'd7;
      return 3'd0;
   endfunction

   function automatic bit in_dac(input logic [15:0] a);
      return (a & 16'hFC00) == 16'h2000;
   endfunction

   function automatic logic [31:0] exp_read(input logic [1:0] sz, input logic [15:0] a);
      if (sz == 2'd0) begin
         if (in_dac(a)) begin
            if (a[9:8] == 2'd0) return {24'h0, m_daddr};
            if (a[9:8] == 2'd3) return {24'h0, m_dmode};
            return 32'h0;
         end
         case (a)
            16'h0000: return {24'h0, m_ctrl};
            16'h0001: return {24'h0, m_path, 4'h0};
            16'h0004: return {28'h0, exp_mon(1152), 1'b0};
            16'h0006: return 32'h30;
            default:  return 32'h0;
         endcase
      end
      if (sz == 2'd1) begin
         case (a)
            16'h0018: return {16'h0, m_hbs};
            16'h001A: return {16'h0, m_hbc};
            16'h0022: return {16'h0, m_vbs};
            16'h0024: return {16'h0, m_vbc};
            default:  return 32'h0;
         endcase
      end
      return 32'h0;
   endfunction

   task automatic geom_step();
      if (m_pend && m_hbs > m_hbc && m_vbs > m_vbc) begin
         m_w = {m_hbs - m_hbc, 2'b00};
         m_h = m_vbs - m_vbc;
      end
   endtask

   task automatic check_outs(input logic pend_n);
      chk("R2 ctrl fields", {28'h0, irq_en, video_en, pix_mode}, {28'h0, m_ctrl[7:4]});
      chk("R3 pix_path", {28'h0, pix_path}, {28'h0, m_path});
      chk("R7 size_changed", {31'h0, size_changed}, {31'h0, pend_n});
      chk("R8 disp_width", {14'h0, disp_width}, {14'h0, m_w});
      chk("R8 disp_height", {16'h0, disp_height}, {16'h0, m_h});
      chk("R9 dac_addr/mode", {16'h0, dac_addr, dac_mode}, {16'h0, m_daddr, m_dmode});
      chk("R10 dac_seq", {24'h0, dac_seq}, {24'h0, m_seq});
   endtask

   task automatic acc(input logic wr, input logic [1:0] sz, input logic [15:0] a,
                      input logic [31:0] d, input string tag);
      logic [31:0] exp_rd;
      logic        pend_n;
      acc_en = 1'b1; acc_wr = wr; acc_size = sz; acc_addr = a; acc_wdata = d;
      exp_rd = exp_read(sz, a);
      @(posedge clk);
      geom_step();
      pend_n = 1'b0;
      if (wr) begin
         if (sz == 2'd0) begin
            if (in_dac(a)) begin
               case (a[9:8])
                  2'd0: begin m_daddr = d[7:0]; m_seq = 8'h0; end
                  2'd1: m_seq = m_seq + 8'h1;
                  2'd3: m_dmode = d[7:0];
                  default: ;
               endcase
            end else if (a == 16'h0000) m_ctrl = d[7:0];
            else if (a == 16'h0001) m_path = d[7:4];
         end else if (sz == 2'd1) begin
            case (a)
               16'h0018: m_hbs = d[15:0];
               16'h001A: begin m_hbc = d[15:0]; pend_n = 1'b1; end
               16'h0022: m_vbs = d[15:0];
               16'h0024: begin m_vbc = d[15:0]; pend_n = 1'b1; end
               default: ;
            endcase
         end
      end else begin
         if (sz == 2'd0 && in_dac(a) && a[9:8] == 2'd1) m_seq = m_seq + 8'h1;
         m_rd = exp_rd;
      end
      @(negedge clk);
      acc_en = 1'b0;
      if (!wr) chk(tag, acc_rdata, exp_rd);
      check_outs(pend_n);
      m_pend = pend_n;
   endtask

   task automatic idle();
      @(posedge clk);
      geom_step();
      @(negedge clk);
      chk("R12 rdata held", acc_rdata, m_rd);
      check_outs(1'b0);
      m_pend = 1'b0;
   endtask

   function automatic logic [15:0] pick(input int i);
      case (i)
         0: return 16'h0000;  1: return 16'h0001;  2: return 16'h0002;
         3: return 16'h0004;  4: return 16'h0006;  5: return 16'h0007;
         6: return 16'h0018;  7: return 16'h001A;  8: return 16'h001C;
         9: return 16'h0022; 10: return 16'h0024; 11: return 16'h0028;
        12: return 16'h2000; 13: return 16'h2100; 14: return 16'h2200;
        15: return 16'h23FF; 16: return 16'h2400; 17: return 16'h3000;
        18: return 16'h2101; default: return 16'h0020;
      endcase
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL R12 watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [31:0] seed_v;
      m_ctrl = 8'h40; m_path = 4'h0;
      m_hbs = 0; m_hbc = 0; m_vbs = 0; m_vbc = 0; m_w = 0; m_h = 0;
      m_daddr = 0; m_dmode = 0; m_seq = 0; m_pend = 0; m_rd = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      chk("R1 rdata after reset", acc_rdata, 32'h0);
      check_outs(1'b0);
      chk("R1 video_en at reset", {31'h0, video_en}, 32'h1);
      acc(0, 2'd0, 16'h0000, 0, "R1 ctrl reset value");

      acc(1, 2'd0, 16'h0000, 32'hB0, "R2");
      acc(0, 2'd0, 16'h0000, 0, "R2 ctrl readback");
      acc(1, 2'd0, 16'h0001, 32'hA5, "R3");
      acc(0, 2'd0, 16'h0001, 0, "R3 path low nibble zero");
      acc(0, 2'd0, 16'h0004, 0, "R4 monitor code");
      acc(0, 2'd0, 16'h0006, 0, "R5 version");

      // geometry: 1152 x 900
      acc(1, 2'd1, 16'h0018, 300, "R6");
      acc(1, 2'd1, 16'h0022, 930, "R6");
      acc(1, 2'd1, 16'h001A, 12, "R7");
      acc(1, 2'd1, 16'h0024, 30, "R7");
      idle();
      chk("R8 width 1152", {14'h0, disp_width}, 32'd1152);
      chk("R8 height 900", {16'h0, disp_height}, 32'd900);
      acc(0, 2'd1, 16'h0018, 0, "R6 hstart readback");
      acc(0, 2'd1, 16'h0024, 0, "R6 vclear readback");
      acc(1, 2'd1, 16'h001C, 32'h1234, "R6 sync ignored");
      acc(0, 2'd1, 16'h001C, 0, "R6 sync reads zero");
      acc(1, 2'd1, 16'h001A, 400, "R8 nonpositive");
      idle();
      chk("R8 width kept", {14'h0, disp_width}, 32'd1152);
      acc(1, 2'd0, 16'h0018, 32'h77, "R11 byte to timing");
      acc(0, 2'd1, 16'h0018, 0, "R11 timing unchanged");

      // DAC window
      acc(1, 2'd0, 16'h2000, 32'h55, "R9");
      acc(0, 2'd0, 16'h2000, 0, "R9 dac addr readback");
      acc(1, 2'd0, 16'h2100, 32'h11, "R10");
      acc(1, 2'd0, 16'h2100, 32'h22, "R10");
      acc(0, 2'd0, 16'h2100, 0, "R9 lut reads zero");
      chk("R10 seq count 3", {24'h0, dac_seq}, 32'd3);
      acc(1, 2'd0, 16'h2300, 32'h06, "R9");
      acc(0, 2'd0, 16'h2300, 0, "R9 mode readback");
      acc(0, 2'd0, 16'h2200, 0, "R9 control reads zero");
      acc(1, 2'd0, 16'h2000, 32'h09, "R10 clear");
      chk("R10 seq cleared", {24'h0, dac_seq}, 32'd0);
      for (int i = 0; i < 256; i++) acc(1, 2'd0, 16'h2100, i, "R10");
      chk("R10 seq wrap", {24'h0, dac_seq}, 32'd0);
      acc(0, 2'd1, 16'h2000, 0, "R11 half to dac");
      acc(0, 2'd0, 16'h2400, 0, "R11 outside dac window");
      acc(0, 2'd2, 16'h0000, 0, "R11 word read");
      acc(1, 2'd2, 16'h0000, 32'hFFFF_FFFF, "R11 word write");
      acc(0, 2'd0, 16'h0000, 0, "R11 ctrl after word write");

      // R12 hold across idle and write
      acc(0, 2'd0, 16'h0006, 0, "R12 read");
      idle();
      acc(1, 2'd0, 16'h0000, 32'h30, "R12");
      idle();

      // constrained random
      seed_v = $urandom(32'd20240611);
      for (int n = 0; n < 600; n++) begin
         logic        w;
         logic [1:0]  s;
         logic [15:0] ad;
         logic [31:0] dv;
         w  = $urandom_range(0, 1) == 1;
         s  = 2'($urandom_range(0, 2));
         ad = pick($urandom_range(0, 19));
         dv = $urandom;
         if (ad == 16'h0018 || ad == 16'h0022) dv[15:12] = 4'h8;
         acc(w, s, ad, dv, "R11 random read");
         if ($urandom_range(0, 7) == 0) idle();
      end

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule